// File: doc/BRIEF.md
# Serial Management Register Read Slave

This block is the slave end of a bit-serial management link driven by an external master. The master supplies the serial clock and a data line. The slave searches the incoming bit stream for a valid command frame. A frame is a run of ones, a two-bit start pattern, an opcode and a device address that must equal the strap value on `phy_addr`. Frames that fail any of these checks are dropped without disturbing the output.

A read command carries an 8-bit register address. The slave answers by shifting out a 32-bit word built from an aligned pair of 16-bit registers, most significant bit first. A clear command carries a selector bit and an 8-bit index. It produces a one-cycle strobe that tells the statistics logic to clear either every counter of one port or a single counter. The register file here is a plain array with a write port on the same clock, which stands in for the real status registers.

Top module: `mgmt_serial_slave`

## Requirements
- R1: A frame is only recognised after at least 32 consecutive ones sampled on `sdi`, followed by a 0 and then a 1. With 31 ones or fewer the start pattern is ignored. Any number of ones beyond 32 is accepted.
- R2: When the second start bit is 0 instead of 1, the slave returns to searching for ones. It produces no read data and no clear strobe.
- R3: The 2-bit opcode follows the start pattern, MSB first. 10 is read and 01 is clear. 00 and 11 abandon the frame with no output.
- R4: The 2-bit device address follows the opcode, MSB first. If it differs from `phy_addr`, the frame is abandoned with no output.
- R5: A read takes an 8-bit register address N, MSB first, and returns register (N with bit 0 set) in bits 31:16 and register (N with bit 0 cleared) in bits 15:0. An even N therefore yields N+1 then N, and an odd N yields N then N-1.
- R6: The first read bit (bit 31) appears on the falling edge that follows the rising edge sampling the last address bit. Each further bit follows on the next falling edge, MSB first. `sdo_en` is high for exactly 32 falling-edge periods.
- R7: Outside the read data phase, `sdo` and `sdo_en` are both 0.
- R8: A clear takes a type bit and then an 8-bit index, MSB first. After the rising edge that samples the last index bit, `clr_stb` is high for exactly one cycle, with `clr_all` equal to the type bit (1 means all counters of the port, 0 means one counter) and `clr_idx` equal to the index.
- R9: Bits on `sdi` during the read data phase are ignored and do not count toward a preamble. After every frame, a new run of 32 ones is needed. A single idle clock between two frames is enough.
- R10: Reset (`rst_n` low) forces `sdo`, `sdo_en` and `clr_stb` to 0 and clears the count of ones, so that a frame cut off by reset needs a full new preamble.
- R11: A write through `wr_en`/`wr_addr`/`wr_data` updates a register on the rising edge of `sck`, and later reads return the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sck | input | 1 | Serial clock from the master; rising edge samples, falling edge drives |
| rst_n | input | 1 | Active-low asynchronous reset |
| phy_addr | input | 2 | Strapped device address compared with the frame |
| sdi | input | 1 | Serial command data from the master |
| sdo | output | 1 | Serial read data, low when idle |
| sdo_en | output | 1 | High while read data is being driven |
| wr_en | input | 1 | Register file write enable |
| wr_addr | input | 8 | Register file write address |
| wr_data | input | 16 | Register file write data |
| clr_stb | output | 1 | One-cycle counter-clear request |
| clr_all | output | 1 | Clear request scope: 1 all counters of a port, 0 one counter |
| clr_idx | output | 8 | Port number or counter index of the clear request |

## Verification
A mistake in the preamble count or the start and address checks shows up as read data or a clear strobe where none should be, or as one missing. This is visible on the first falling edge after the frame's final bit. A wrong pair-alignment or shift order corrupts the `sdo` bit stream within 32 periods of the read starting, and a wrong phase length shows as `sdo_en` dropping early or staying high. The bench therefore compares `sdo`, `sdo_en` and `clr_stb` on every clock against a queue of expected values, and compares the clear fields whenever a strobe is due.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

    typedef enum logic [2:0] {
        S_HUNT,
        S_START,
        S_OPC,
        S_DEV,
        S_REGA,
        S_RDATA,
        S_CTYPE,
        S_CIDX
    } rx_state_e;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_CLEAR = 2'b01;

endpackage

// File: rtl/mgmt_regfile.sv
module mgmt_regfile #(
    parameter int RA_W  = 8,
    parameter int REG_W = 16
) (
    input  logic                 sck,
    input  logic                 wr_en,
    input  logic [RA_W-1:0]      wr_addr,
    input  logic [REG_W-1:0]     wr_data,
    input  logic [RA_W-1:0]      rd_addr,
    output logic [2*REG_W-1:0]   pair
);
    localparam int NUM_REGS = 1 << RA_W;

    logic [REG_W-1:0] mem_q [NUM_REGS];
    logic [RA_W-1:0]  hi_idx;
    logic [RA_W-1:0]  lo_idx;

    always_ff @(posedge sck) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        hi_idx = rd_addr | RA_W'(1);
        lo_idx = rd_addr & ~RA_W'(1);
        pair   = {mem_q[hi_idx], mem_q[lo_idx]};
    end

endmodule

// File: rtl/mgmt_frame_rx.sv
module mgmt_frame_rx
    import mgmt_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int RA_W    = 8,
    parameter int DATA_W  = 32
) (
    input  logic             sck,
    input  logic             rst_n,
    input  logic             sdi,
    input  logic [1:0]       phy_addr,
    output logic             rd_active,
    output logic             rd_first,
    output logic [RA_W-1:0]  rd_addr,
    output logic             clr_stb,
    output logic             clr_all,
    output logic [RA_W-1:0]  clr_idx
);
    localparam int CNT_W = $clog2(PRE_LEN + 1);
    localparam int BC_W  = $clog2(DATA_W);

    typedef struct packed {
        rx_state_e          state;
        logic [CNT_W-1:0]   ones;
        logic [BC_W-1:0]    bitcnt;
        logic [RA_W-1:0]    sh;
        logic [1:0]         opc;
        logic               ctype;
        logic [RA_W-1:0]    rd_addr;
        logic               clr_stb;
        logic               clr_all;
        logic [RA_W-1:0]    clr_idx;
    } rx_t;

    rx_t r_d, r_q;
    logic [RA_W-1:0] sh_next;
    logic [1:0]      pair2;

    always_comb begin
        r_d         = r_q;
        r_d.clr_stb = 1'b0;
        sh_next     = {r_q.sh[RA_W-2:0], sdi};
        pair2       = {r_q.sh[0], sdi};
        case (r_q.state)
            S_HUNT: begin
                if (sdi) begin
                    if (r_q.ones != CNT_W'(PRE_LEN)) r_d.ones = r_q.ones + 1'b1;
                end else if (r_q.ones == CNT_W'(PRE_LEN)) begin
                    r_d.state = S_START;
                    r_d.ones  = '0;
                end else begin
                    r_d.ones = '0;
                end
            end
            S_START: begin
                r_d.ones   = '0;
                r_d.bitcnt = '0;
                r_d.state  = sdi ? S_OPC : S_HUNT;
            end
            S_OPC: begin
                r_d.sh     = sh_next;
                r_d.bitcnt = r_q.bitcnt + 1'b1;
                if (r_q.bitcnt == BC_W'(1)) begin
                    r_d.opc    = pair2;
                    r_d.bitcnt = '0;
                    r_d.state  = (pair2 == OPC_READ || pair2 == OPC_CLEAR) ? S_DEV : S_HUNT;
                end
            end
            S_DEV: begin
                r_d.sh     = sh_next;
                r_d.bitcnt = r_q.bitcnt + 1'b1;
                if (r_q.bitcnt == BC_W'(1)) begin
                    r_d.bitcnt = '0;
                    if (pair2 != phy_addr)        r_d.state = S_HUNT;
                    else if (r_q.opc == OPC_READ) r_d.state = S_REGA;
                    else                          r_d.state = S_CTYPE;
                end
            end
            S_REGA: begin
                r_d.sh     = sh_next;
                r_d.bitcnt = r_q.bitcnt + 1'b1;
                if (r_q.bitcnt == BC_W'(RA_W - 1)) begin
                    r_d.rd_addr = sh_next;
                    r_d.bitcnt  = '0;
                    r_d.state   = S_RDATA;
                end
            end
            S_RDATA: begin
                r_d.bitcnt = r_q.bitcnt + 1'b1;
                if (r_q.bitcnt == BC_W'(DATA_W - 1)) begin
                    r_d.bitcnt = '0;
                    r_d.state  = S_HUNT;
                end
            end
            S_CTYPE: begin
                r_d.ctype  = sdi;
                r_d.bitcnt = '0;
                r_d.state  = S_CIDX;
            end
            S_CIDX: begin
                r_d.sh     = sh_next;
                r_d.bitcnt = r_q.bitcnt + 1'b1;
                if (r_q.bitcnt == BC_W'(RA_W - 1)) begin
                    r_d.clr_stb = 1'b1;
                    r_d.clr_all = r_q.ctype;
                    r_d.clr_idx = sh_next;
                    r_d.bitcnt  = '0;
                    r_d.state   = S_HUNT;
                end
            end
            default: r_d.state = S_HUNT;
        endcase
    end

    always_ff @(posedge sck or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= S_HUNT;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_active = (r_q.state == S_RDATA);
    assign rd_first  = (r_q.state == S_RDATA) && (r_q.bitcnt == '0);
    assign rd_addr   = r_q.rd_addr;
    assign clr_stb   = r_q.clr_stb;
    assign clr_all   = r_q.clr_all;
    assign clr_idx   = r_q.clr_idx;

    // R1
    preamble_len_chk: assert property (@(posedge sck) disable iff (!rst_n)
        (r_q.state == S_START) |-> ($past(r_q.ones) == CNT_W'(PRE_LEN)));

    // R4
    dev_match_chk: assert property (@(posedge sck) disable iff (!rst_n)
        ((r_q.state == S_REGA || r_q.state == S_CTYPE) && $past(r_q.state) == S_DEV)
        |-> ($past({r_q.sh[0], sdi}) == phy_addr));

    // R8
    clr_pulse_chk: assert property (@(posedge sck) disable iff (!rst_n)
        r_q.clr_stb |=> !r_q.clr_stb);

    // R5
    rd_entry_chk: assert property (@(posedge sck) disable iff (!rst_n)
        (r_q.state == S_RDATA && $past(r_q.state) != S_RDATA) |-> ($past(r_q.state) == S_REGA));

endmodule

// File: rtl/mgmt_tx_shift.sv
module mgmt_tx_shift #(
    parameter int DATA_W = 32
) (
    input  logic              sck,
    input  logic              rst_n,
    input  logic              rd_active,
    input  logic              rd_first,
    input  logic [DATA_W-1:0] word,
    output logic              sdo,
    output logic              sdo_en
);
    localparam int RUN_W = $clog2(DATA_W + 1);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic              en;
        logic [RUN_W-1:0]  run;
    } tx_t;

    tx_t t_d, t_q;

    always_comb begin
        t_d    = t_q;
        t_d.en = rd_active;
        if (rd_first)       t_d.sh = word;
        else if (rd_active) t_d.sh = t_q.sh << 1;
        else                t_d.sh = '0;
        t_d.run = rd_active ? t_q.run + 1'b1 : '0;
    end

    always_ff @(negedge sck or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign sdo    = t_q.sh[DATA_W-1] & t_q.en;
    assign sdo_en = t_q.en;

    // R6
    read_len_chk: assert property (@(negedge sck) disable iff (!rst_n)
        $fell(t_q.en) |-> ($past(t_q.run) == RUN_W'(DATA_W)));

    // R7
    idle_low_chk: assert property (@(negedge sck) disable iff (!rst_n)
        !rd_active |=> !t_q.en);

endmodule

// File: rtl/mgmt_serial_slave.sv
module mgmt_serial_slave #(
    parameter int PRE_LEN = 32,
    parameter int RA_W    = 8,
    parameter int REG_W   = 16
) (
    input  logic             sck,
    input  logic             rst_n,
    input  logic [1:0]       phy_addr,
    input  logic             sdi,
    output logic             sdo,
    output logic             sdo_en,
    input  logic             wr_en,
    input  logic [RA_W-1:0]  wr_addr,
    input  logic [REG_W-1:0] wr_data,
    output logic             clr_stb,
    output logic             clr_all,
    output logic [RA_W-1:0]  clr_idx
);
    localparam int DATA_W = 2 * REG_W;

    logic              rd_active;
    logic              rd_first;
    logic [RA_W-1:0]   rd_addr;
    logic [DATA_W-1:0] pair;

    mgmt_frame_rx #(.PRE_LEN(PRE_LEN), .RA_W(RA_W), .DATA_W(DATA_W)) u_rx (
        .sck(sck), .rst_n(rst_n), .sdi(sdi), .phy_addr(phy_addr),
        .rd_active(rd_active), .rd_first(rd_first), .rd_addr(rd_addr),
        .clr_stb(clr_stb), .clr_all(clr_all), .clr_idx(clr_idx)
    );

    mgmt_regfile #(.RA_W(RA_W), .REG_W(REG_W)) u_regs (
        .sck(sck), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .pair(pair)
    );

    mgmt_tx_shift #(.DATA_W(DATA_W)) u_tx (
        .sck(sck), .rst_n(rst_n), .rd_active(rd_active), .rd_first(rd_first),
        .word(pair), .sdo(sdo), .sdo_en(sdo_en)
    );

endmodule

// File: tb/mgmt_serial_slave_bench.sv
module mgmt_serial_slave_bench;

    logic        sck = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  phy_addr = 2'b10;
    logic        sdi = 1'b0;
    logic        sdo, sdo_en;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        clr_stb, clr_all;
    logic [7:0]  clr_idx;

    int checks = 0;
    int fails  = 0;

    logic [15:0] mdl [256];

    bit          q_b[$];
    bit          q_en[$];
    bit          q_do[$];
    bit          q_cs[$];
    bit          q_ca[$];
    logic [7:0]  q_ci[$];
    string       q_tag[$];
    string       cur_tag = "R7";

    always #5 sck = ~sck;

    mgmt_serial_slave u_mgmt_serial_slave (
        .sck(sck), .rst_n(rst_n), .phy_addr(phy_addr), .sdi(sdi),
        .sdo(sdo), .sdo_en(sdo_en), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .clr_stb(clr_stb), .clr_all(clr_all), .clr_idx(clr_idx)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic emit(bit b);
        q_b.push_back(b); q_en.push_back(1'b0); q_do.push_back(1'b0);
        q_cs.push_back(1'b0); q_ca.push_back(1'b0); q_ci.push_back(8'h00);
        q_tag.push_back(cur_tag);
    endtask

    task automatic emit_bits(logic [31:0] v, int n);
        for (int i = n - 1; i >= 0; i--) emit(v[i]);
    endtask

    task automatic preamble_start(int pre, logic [1:0] st);
        for (int i = 0; i < pre; i++) emit(1'b1);
        emit_bits(32'(st), 2);
    endtask

    task automatic read_frame(int pre, logic [1:0] st, logic [1:0] opc, logic [1:0] dev,
                              logic [7:0] ra, bit ok, string tag);
        int k;
        logic [31:0] w;
        cur_tag = tag;
        preamble_start(pre, st);
        emit_bits(32'(opc), 2);
        emit_bits(32'(dev), 2);
        emit_bits(32'(ra), 8);
        k = q_b.size() - 1;
        for (int i = 0; i < 32; i++) emit(ok);
        if (ok) begin
            w = {mdl[ra | 8'h01], mdl[ra & 8'hFE]};
            for (int i = 0; i < 32; i++) begin
                q_en[k + 1 + i] = 1'b1;
                q_do[k + 1 + i] = w[31 - i];
            end
        end
    endtask

    task automatic clear_frame(int pre, logic [1:0] dev, bit typ, logic [7:0] idx,
                               bit ok, string tag);
        int k;
        cur_tag = tag;
        preamble_start(pre, 2'b01);
        emit_bits(32'(2'b01), 2);
        emit_bits(32'(dev), 2);
        emit(typ);
        emit_bits(32'(idx), 8);
        k = q_b.size() - 1;
        emit(1'b0);
        if (ok) begin
            q_cs[k + 1] = 1'b1;
            q_ca[k + 1] = typ;
            q_ci[k + 1] = idx;
        end
    endtask

    task automatic run();
        while (q_b.size() > 0) begin
            bit b, e_en, e_do, e_cs, e_ca;
            logic [7:0] e_ci;
            string t;
            b = q_b.pop_front(); e_en = q_en.pop_front(); e_do = q_do.pop_front();
            e_cs = q_cs.pop_front(); e_ca = q_ca.pop_front(); e_ci = q_ci.pop_front();
            t = q_tag.pop_front();
            @(negedge sck); #1;
            check(t, "sdo_en", int'(sdo_en), int'(e_en));
            check(t, "sdo", int'(sdo), int'(e_do));
            check(t, "clr_stb", int'(clr_stb), int'(e_cs));
            if (e_cs) begin
                check(t, "clr_all", int'(clr_all), int'(e_ca));
                check(t, "clr_idx", int'(clr_idx), int'(e_ci));
            end
            sdi = b;
        end
    endtask

    task automatic write_reg(logic [7:0] a, logic [15:0] v);
        @(negedge sck);
        sdi = 1'b0; wr_en = 1'b1; wr_addr = a; wr_data = v;
        mdl[a] = v;
        @(negedge sck);
        wr_en = 1'b0;
    endtask

    initial begin
        #1_000_000;
        fails++; checks++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge sck);
        #1;
        check("R10", "sdo_en in reset", int'(sdo_en), 0);
        check("R10", "sdo in reset", int'(sdo), 0);
        check("R10", "clr_stb in reset", int'(clr_stb), 0);
        @(negedge sck);
        rst_n = 1'b1;

        for (int i = 0; i < 256; i++) write_reg(8'(i), 16'(i * 16'h0101) ^ 16'hC35A);

        // R5 R6: even, odd and edge addresses
        read_frame(32, 2'b01, 2'b10, 2'b10, 8'h04, 1'b1, "R5"); emit(0);
        read_frame(32, 2'b01, 2'b10, 2'b10, 8'h07, 1'b1, "R5"); emit(0);
        read_frame(32, 2'b01, 2'b10, 2'b10, 8'h00, 1'b1, "R6"); emit(0);
        read_frame(40, 2'b01, 2'b10, 2'b10, 8'hFF, 1'b1, "R1"); emit(0);
        // R1: 31 ones is too short
        read_frame(31, 2'b01, 2'b10, 2'b10, 8'h04, 1'b0, "R1"); emit(0);
        // R2: bad start
        read_frame(32, 2'b00, 2'b10, 2'b10, 8'h04, 1'b0, "R2"); emit(0);
        // R3: invalid opcodes
        read_frame(32, 2'b01, 2'b00, 2'b10, 8'h04, 1'b0, "R3"); emit(0);
        read_frame(32, 2'b01, 2'b11, 2'b10, 8'h04, 1'b0, "R3"); emit(0);
        // R4: wrong device address
        read_frame(32, 2'b01, 2'b10, 2'b01, 8'h04, 1'b0, "R4"); emit(0);
        clear_frame(32, 2'b11, 1'b1, 8'h03, 1'b0, "R4");
        // R8: clears of both types
        clear_frame(32, 2'b10, 1'b1, 8'h03, 1'b1, "R8");
        clear_frame(35, 2'b10, 1'b0, 8'h5A, 1'b1, "R8");
        // R9: data-phase ones ignored, then back-to-back frames
        read_frame(32, 2'b01, 2'b10, 2'b10, 8'h10, 1'b1, "R9");
        read_frame(0, 2'b01, 2'b10, 2'b10, 8'h10, 1'b0, "R9"); emit(0);
        read_frame(32, 2'b01, 2'b10, 2'b10, 8'h21, 1'b1, "R9"); emit(0);
        read_frame(32, 2'b01, 2'b10, 2'b10, 8'h22, 1'b1, "R9"); emit(0);
        cur_tag = "R7"; emit(0); emit(0);
        run();

        // R11: writes become visible
        write_reg(8'h04, 16'hBEEF);
        write_reg(8'h05, 16'h1234);
        read_frame(32, 2'b01, 2'b10, 2'b10, 8'h05, 1'b1, "R11"); emit(0); emit(0);
        run();

        // R10: reset mid-frame clears the ones count
        cur_tag = "R10";
        preamble_start(32, 2'b01);
        emit_bits(32'(2'b10), 2);
        run();
        @(negedge sck); rst_n = 1'b0; #1;
        check("R10", "sdo_en after mid-frame reset", int'(sdo_en), 0);
        @(negedge sck); rst_n = 1'b1;
        read_frame(0, 2'b01, 2'b10, 2'b10, 8'h04, 1'b0, "R10"); emit(0);
        read_frame(32, 2'b01, 2'b10, 2'b10, 8'h04, 1'b1, "R10"); emit(0); emit(0);
        run();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule